// File: doc/BRIEF.md
# Output-Compare PWM Timer Channel

This block is a free-running up-counter, driven through a power-of-two clock divider and limited by a programmable period value, with one output-compare channel that drives a pulse-width-modulated pin. On each divider tick the counter advances. After it reaches the period value it wraps to zero. The pin responds to two events: the wrap (end of period) and the counter reaching the channel compare value (end of pulse). An invert bit chooses which of the two events drives the pin high and which drives it low. Each event also sets its own sticky interrupt flag. Software clears a flag by pulsing that flag's clear input.

The compare value has no holding register. A bus write changes it on the next clock, even in the middle of a period. A write can therefore move the compare point behind the counter, so no compare happens in that period. It can also move the compare point ahead of a compare that has already fired, so a second compare happens in the same period. Software avoids this by writing smaller values after the compare flag and larger values after the overflow flag. A 2-bit mode field selects PWM drive, toggle-on-compare or a pin held low. Toggle mode exists but gives no reliable 0 % duty.

Top module: `pwm_oc_timer`

## Requirements
- R1: A write with `wr_en` high loads `wr_data` into a register chosen by `wr_addr`: 0 is the period value, 1 is the compare value, 2 is control. Control bits [2:0] are the divider select. Bits [4:3] are the output mode: 00 pin held low, 01 toggle on compare, 10 PWM, 11 pin held low. Bit 5 is the invert bit.
- R2: The counter steps once per divider tick and wraps from the period value to 0. A tick occurs every 2^s clocks for select s = 0..6, and every 64 clocks for s = 7. One period is therefore (period value + 1) × divider clocks.
- R3: In PWM mode with invert 0, the pin goes high on the wrap and goes low when the counter steps to the compare value. It is high while the counter is below the compare value: period 255 with compare 128 gives 128 high clocks in 256.
- R4: In PWM mode with invert 1, the wrap drives the pin low and the compare drives it high. Period 255 with compare 64 gives 192 high clocks in 256.
- R5: When a wrap and a compare fall on the same tick, the wrap's pin action wins. A compare value of 0, or one above the period value, therefore holds the pin high in every period with invert 0.
- R6: The compare flag sets on the tick where the counter steps to the compare value. The overflow flag sets on the tick where the counter wraps.
- R7: Each flag stays set until its clear input is high at a clock edge. An event at the same edge as a clear leaves the flag set.
- R8: A compare value written after the counter has already passed it, while the old value is still ahead, gives no compare and no pin change for the rest of that period. The new value applies from the next period.
- R9: Raising the compare value after the compare has fired, to a value the counter has not yet reached, gives a second compare in the same period.
- R10: In toggle mode each compare inverts the pin and the wrap leaves the pin unchanged.
- R11: In the held-low modes the pin stays 0, and both flags still operate.
- R12: A synchronous reset clears the counter, the divider, both flags, the pin and the control register. It also sets the period value to all ones and the compare value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 compare, 2 control |
| wr_data | input | 16 | Write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| cmp_clr | input | 1 | Clears the compare flag |
| pwm_out | output | 1 | Channel pin |
| ovf_flag | output | 1 | Overflow (end of period) interrupt flag |
| cmp_flag | output | 1 | Compare (end of pulse) interrupt flag |

## Verification
The assertions check, on every cycle, the local rules that tie events to state:
- A wrap or a compare sets its flag, and a flag holds or clears according to its clear input.
- In PWM mode the pin takes the level the invert bit gives it after each event, and holds that level between events.
- The held-low modes keep the pin at 0.
- A wrap leaves the counter at 0, and reset clears the state.

Only the bench scenarios can show the effects that depend on a whole period:
- duty ratios and period lengths under different divider selects;
- the wrap taking priority at the end points of the compare range;
- a compare missed, or fired twice, after live writes of the compare value;
- toggle mode inverting the pin once per period.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int SEL_W     = 3;
    localparam int MAX_SHIFT = 6;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_TOGGLE = 2'b01,
        MODE_PWM    = 2'b10,
        MODE_RSVD   = 2'b11
    } out_mode_e;

    // Control word layout: [5] invert, [4:3] mode, [2:0] divider select
    typedef struct packed {
        logic             invert;
        out_mode_e        mode;
        logic [SEL_W-1:0] div_sel;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] ADDR_PERIOD  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_COMPARE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 2'd2;
endpackage

// File: rtl/pwm_oc_regs.sv
module pwm_oc_regs
    import pwm_oc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] period_o,
    output logic [DW-1:0] compare_o,
    output ctrl_t         ctrl_o
);
    localparam int CW = $bits(ctrl_t);

    typedef struct packed {
        logic [DW-1:0] period;
        logic [DW-1:0] compare;
        ctrl_t         ctrl;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_hi;

    assign unused_hi = ^wr_data[DW-1:CW];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_PERIOD:  r_d.period  = wr_data;
                ADDR_COMPARE: r_d.compare = wr_data;
                ADDR_CTRL:    r_d.ctrl    = ctrl_t'(wr_data[CW-1:0]);
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= regs_t'({{DW{1'b1}}, {DW{1'b0}}, {CW{1'b0}}});
        else     r_q <= r_d;
    end

    assign period_o  = r_q.period;
    assign compare_o = r_q.compare;
    assign ctrl_o    = r_q.ctrl;
endmodule

// File: rtl/pwm_oc_presc.sv
module pwm_oc_presc #(
    parameter int SW        = 3,
    parameter int MAX_SHIFT = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int DIV_W = MAX_SHIFT;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;
    int               shift;

    always_comb begin
        shift = (int'(sel) > MAX_SHIFT) ? MAX_SHIFT : int'(sel);
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < shift);
        end
        tick  = ((div_q & mask) == mask);
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end
endmodule

// File: rtl/pwm_oc_count.sv
module pwm_oc_count #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [DW-1:0] period,
    input  logic [DW-1:0] compare,
    output logic [DW-1:0] cnt,
    output logic          ovf_ev,
    output logic          cmp_ev
);
    logic [DW-1:0] cnt_d, cnt_q;
    logic [DW-1:0] step;
    logic          at_end;

    always_comb begin
        at_end = (cnt_q == period);
        step   = at_end ? '0 : cnt_q + 1'b1;
        ovf_ev = tick && at_end;
        cmp_ev = tick && (step == compare);
        cnt_d  = tick ? step : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pwm_oc_pin.sv
module pwm_oc_pin
    import pwm_oc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ovf_ev,
    input  logic      cmp_ev,
    input  logic      ovf_clr,
    input  logic      cmp_clr,
    input  out_mode_e mode,
    input  logic      invert,
    output logic      pin,
    output logic      ovf_flag,
    output logic      cmp_flag
);
    typedef struct packed {
        logic pin;
        logic ovf;
        logic cmp;
    } pin_st_t;

    pin_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = ovf_ev | (s_q.ovf & ~ovf_clr);
        s_d.cmp = cmp_ev | (s_q.cmp & ~cmp_clr);
        case (mode)
            MODE_PWM: begin
                if (ovf_ev)      s_d.pin = ~invert;
                else if (cmp_ev) s_d.pin = invert;
            end
            MODE_TOGGLE: begin
                if (cmp_ev) s_d.pin = ~s_q.pin;
            end
            default: s_d.pin = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pin      = s_q.pin;
    assign ovf_flag = s_q.ovf;
    assign cmp_flag = s_q.cmp;
endmodule

// File: rtl/pwm_oc_timer.sv
module pwm_oc_timer
    import pwm_oc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ovf_clr,
    input  logic          cmp_clr,
    output logic          pwm_out,
    output logic          ovf_flag,
    output logic          cmp_flag
);
    logic [DW-1:0] period_w, compare_w, cnt_w;
    ctrl_t         ctrl_w;
    logic          tick_w, ovf_ev, cmp_ev;

    pwm_oc_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .period_o(period_w), .compare_o(compare_w), .ctrl_o(ctrl_w)
    );

    pwm_oc_presc #(.SW(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_presc (
        .clk(clk), .rst(rst), .sel(ctrl_w.div_sel), .tick(tick_w)
    );

    pwm_oc_count #(.DW(DW)) u_count (
        .clk(clk), .rst(rst), .tick(tick_w), .period(period_w), .compare(compare_w),
        .cnt(cnt_w), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev)
    );

    pwm_oc_pin u_pin (
        .clk(clk), .rst(rst), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev),
        .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
        .mode(ctrl_w.mode), .invert(ctrl_w.invert),
        .pin(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );
endmodule

// File: rtl/pwm_oc_timer_chk.sv
module pwm_oc_timer_chk
    import pwm_oc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst,
    input logic          ovf_clr,
    input logic          cmp_clr,
    input logic          pwm_out,
    input logic          ovf_flag,
    input logic          cmp_flag,
    input logic          ovf_ev,
    input logic          cmp_ev,
    input out_mode_e     mode,
    input logic          invert,
    input logic [DW-1:0] cnt
);
    AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> ovf_flag);                                         // R6
    AST_CMP_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        cmp_ev |=> cmp_flag);                                         // R6
    AST_OVF_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);                         // R7
    AST_CMP_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmp_flag && cmp_clr && !cmp_ev) |=> !cmp_flag);              // R7
    AST_PWM_WRAP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PWM && ovf_ev) |=> (pwm_out == !invert));       // R3
    AST_PWM_CMP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PWM && cmp_ev && !ovf_ev) |=> (pwm_out == invert)); // R4
    AST_PWM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PWM && !ovf_ev && !cmp_ev) |=> $stable(pwm_out)); // R3
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |=> !pwm_out);                             // R11
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> (cnt == '0));                                      // R2
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!pwm_out && !ovf_flag && !cmp_flag && cnt == '0));   // R12
endmodule

bind pwm_oc_timer pwm_oc_timer_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
    .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .ovf_ev(ovf_ev), .cmp_ev(cmp_ev), .mode(ctrl_w.mode), .invert(ctrl_w.invert),
    .cnt(cnt_w)
);

// File: tb/sim_pwm_oc_timer.sv
`timescale 1ns/1ps
module sim_pwm_oc_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        ovf_clr, cmp_clr;
    logic        pwm_out, ovf_flag, cmp_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwm_oc_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
        .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    localparam logic [1:0] M_OFF = 2'b00, M_TGL = 2'b01, M_PWM = 2'b10;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_ctrl(input bit inv, input logic [1:0] mode, input logic [2:0] sel);
        return {10'b0, inv, mode, sel};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int per, input int cmpv, input logic [15:0] ctrl);
        wr(2'd0, 16'(per));
        wr(2'd1, 16'(cmpv));
        wr(2'd2, ctrl);
    endtask

    // Leaves the bench at the negedge right after a wrap (counter at 0)
    task automatic wait_ovf;
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        while (!ovf_flag) @(negedge clk);
    endtask

    task automatic measure(input int n, output int high, output int cmp_at,
                           output int ovf_pre, output int ovf_end);
        high = 0; cmp_at = -1; ovf_pre = 0;
        for (int i = 0; i < n; i++) begin
            ovf_clr = (i == 0);
            cmp_clr = (i == 0);
            if (pwm_out) high++;
            if (i >= 1 && cmp_flag && cmp_at < 0) cmp_at = i;
            if (i == n - 1) ovf_pre = ovf_flag;
            @(negedge clk);
        end
        ovf_clr = 1'b0; cmp_clr = 1'b0;
        ovf_end = ovf_flag;
    endtask

    task automatic t_reset_state;
        chk("R12", "pin after reset", pwm_out, 0);
        chk("R12", "ovf flag after reset", ovf_flag, 0);
        chk("R12", "cmp flag after reset", cmp_flag, 0);
    endtask

    task automatic t_duty_half;
        int h, c, p, e;
        cfg(255, 128, mk_ctrl(0, M_PWM, 3'd0));
        wait_ovf();
        measure(256, h, c, p, e);
        chk("R3", "high clocks, period 255 compare 128", h, 128);
        chk("R6", "compare flag index", c, 128);
        chk("R2", "ovf flag before period end", p, 0);
        chk("R2", "ovf flag at period end", e, 1);
        chk("R1", "pin high at new period", pwm_out, 1);
    endtask

    task automatic t_divider;
        int h, c, p, e;
        cfg(9, 3, mk_ctrl(0, M_PWM, 3'd2));
        wait_ovf();
        measure(40, h, c, p, e);
        chk("R2", "high clocks, divide by 4", h, 12);
        chk("R2", "ovf before 40 clocks", p, 0);
        chk("R2", "ovf at 40 clocks", e, 1);
        chk("R6", "compare flag index, divide by 4", c, 12);
        cfg(1, 1, mk_ctrl(0, M_PWM, 3'd7));
        wait_ovf();
        measure(128, h, c, p, e);
        chk("R2", "high clocks, select 7", h, 64);
        chk("R2", "ovf at 128 clocks, select 7", e, 1);
        chk("R2", "no ovf before 128 clocks, select 7", p, 0);
    endtask

    task automatic t_invert;
        int h, c, p, e;
        cfg(255, 64, mk_ctrl(1, M_PWM, 3'd0));
        wait_ovf();
        measure(256, h, c, p, e);
        chk("R4", "high clocks inverted, compare 64", h, 192);
    endtask

    task automatic t_priority;
        int h, c, p, e;
        cfg(99, 0, mk_ctrl(0, M_PWM, 3'd0));
        wait_ovf();
        measure(100, h, c, p, e);
        chk("R5", "compare 0 holds pin high", h, 100);
        wr(2'd1, 16'd200);
        wait_ovf();
        measure(100, h, c, p, e);
        chk("R5", "compare above period holds pin high", h, 100);
    endtask

    task automatic t_skip;
        int h, c, p, e, low, seen;
        cfg(255, 100, mk_ctrl(0, M_PWM, 3'd0));
        wait_ovf();
        low = 0; seen = 0;
        for (int i = 0; i < 256; i++) begin
            ovf_clr = (i == 0);
            cmp_clr = (i == 0);
            wr_en   = (i == 50);
            wr_addr = 2'd1;
            wr_data = 16'd30;
            if (i >= 1 && !pwm_out) low++;
            if (i >= 1 && cmp_flag) seen = 1;
            @(negedge clk);
        end
        ovf_clr = 1'b0; cmp_clr = 1'b0; wr_en = 1'b0;
        chk("R8", "pin low clocks after skipped compare", low, 0);
        chk("R8", "compare flag after skipped compare", seen, 0);
        chk("R8", "wrap still at period end", ovf_flag, 1);
        measure(256, h, c, p, e);
        chk("R8", "new compare applies next period", h, 30);
    endtask

    task automatic t_double;
        cfg(255, 20, mk_ctrl(0, M_PWM, 3'd0));
        wait_ovf();
        for (int i = 0; i < 256; i++) begin
            ovf_clr = (i == 0);
            cmp_clr = (i == 0) || (i == 40);
            wr_en   = (i == 40);
            wr_addr = 2'd1;
            wr_data = 16'd100;
            if (i == 40) chk("R6", "first compare flag", cmp_flag, 1);
            if (i == 99) chk("R9", "flag clear before second compare", cmp_flag, 0);
            if (i == 100) begin
                chk("R9", "second compare in same period", cmp_flag, 1);
                chk("R9", "pin low after second compare", pwm_out, 0);
            end
            @(negedge clk);
        end
        ovf_clr = 1'b0; cmp_clr = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_toggle;
        logic p0, p_last;
        cfg(255, 128, mk_ctrl(0, M_TGL, 3'd0));
        wait_ovf();
        p0 = pwm_out; p_last = pwm_out;
        for (int i = 0; i < 256; i++) begin
            if (i == 127) chk("R10", "pin before compare", pwm_out, p0);
            if (i == 128) chk("R10", "pin toggled at compare", pwm_out, !p0);
            p_last = pwm_out;
            @(negedge clk);
        end
        chk("R10", "wrap leaves pin unchanged", pwm_out, p_last);
    endtask

    task automatic t_off;
        int h, c, p, e;
        cfg(255, 128, mk_ctrl(0, M_OFF, 3'd0));
        wait_ovf();
        measure(256, h, c, p, e);
        chk("R11", "pin high clocks in held-low mode", h, 0);
        chk("R11", "ovf flag still set", e, 1);
        chk("R11", "cmp flag still set", c, 128);
    endtask

    task automatic t_flags;
        cfg(255, 128, mk_ctrl(0, M_PWM, 3'd0));
        wait_ovf();
        for (int i = 0; i < 256; i++) begin
            if (i == 200) chk("R7", "ovf flag sticky", ovf_flag, 1);
            ovf_clr = (i == 255);
            @(negedge clk);
        end
        chk("R7", "event wins over clear", ovf_flag, 1);
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R7", "clear without event", ovf_flag, 0);
    endtask

    task automatic t_reset_mid;
        cfg(255, 128, mk_ctrl(0, M_PWM, 3'd0));
        wait_ovf();
        repeat (10) @(negedge clk);
        chk("R12", "pin high before reset", pwm_out, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        repeat (300) @(negedge clk);
        chk("R12", "control cleared, pin low", pwm_out, 0);
        chk("R12", "period all ones, no ovf yet", ovf_flag, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ovf_clr = 1'b0; cmp_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_duty_half();
        t_divider();
        t_invert();
        t_priority();
        t_skip();
        t_double();
        t_toggle();
        t_off();
        t_flags();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule